// File: doc/BRIEF.md
# Command/Indication Code Channel Handler

This block carries short command/indication codes across the control bits of a time-division frame bus in two independent channels. Channel 0 moves a fixed 4-bit code. Channel 1 moves a 6-bit field, and that field can be narrowed so that only its low 4 bits count as the code. A one-cycle frame tick marks the moment in each frame when the received control bits are valid and when a new transmit value may take over.

On the receive side, a value is accepted only when it arrives unchanged in two consecutive frames. It is latched for the host only if the host has already read the code latched before it. Each latch raises a per-channel change flag. The two flags together drive one interrupt line, and a read strobe clears a flag.

On the transmit side, the host writes a code into a pending slot. The code is adopted at a frame tick, and it is then kept for a minimum number of frames so that unconditional commands last long enough for the far end to see them. Channel 0 drives its code only while this device holds the control arbitration bus. Channel 1 drives its code only while the channel is enabled. In every other case the bits idle at all ones.

Top module: `ci_link_top`

## Requirements
- R1: A received code is latched only at a frame tick where it equals (under the channel's compare mask) the value received at the previous frame tick; the first tick after reset never latches.
- R2: A new code is latched only while the channel's change flag is clear, or while the host read strobe for that channel is high in the same cycle.
- R3: A latch sets the channel's change flag in the next cycle, and a read strobe without a latch clears it. `irq` is high whenever either flag is set.
- R4: `ci0_tx` carries the adopted channel 0 code while `bus_held` is 1 and all ones (4'hF) while it is 0.
- R5: With `ch1_narrow`=1, channel 1 compares only bits [3:0]. A received change confined to bits [5:4] neither latches nor sets the flag. Latched and transmitted values still keep all 6 bits as received or as written.
- R6: With `ch1_en`=0, channel 1 latches nothing and `ci1_tx` is all ones (6'h3F).
- R7: When a read strobe and a qualifying latch meet in one cycle, the host sees the old code during that cycle, the new code is stored, and the flag stays set.
- R8: A written transmit code takes effect at the next frame tick at the earliest. Once adopted, a code stays in force for at least MIN_HOLD (default 4) frame ticks before a later write replaces it, and the most recent write wins.
- R9: After reset, both latched codes are all ones, both flags and `irq` are 0, and both transmit outputs are all ones.
- R10: The persistence check compares only against the immediately preceding frame, so a sequence A, B, A does not latch A until A is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame; received bits valid |
| ci0_rx | input | 4 | Received channel 0 code |
| ci1_rx | input | 6 | Received channel 1 field |
| bus_held | input | 1 | This device holds the arbitration bus |
| ch1_en | input | 1 | Channel 1 enable |
| ch1_narrow | input | 1 | 1: channel 1 compares 4 bits |
| wr0 | input | 1 | Write strobe, channel 0 transmit code |
| wr1 | input | 1 | Write strobe, channel 1 transmit code |
| wdata | input | 6 | Write data (channel 0 uses bits [3:0]) |
| rd0 | input | 1 | Host read strobe, channel 0 |
| rd1 | input | 1 | Host read strobe, channel 1 |
| ci0_code | output | 4 | Latched channel 0 code |
| ci1_code | output | 6 | Latched channel 1 field |
| ci0_chg | output | 1 | Channel 0 change flag |
| ci1_chg | output | 1 | Channel 1 change flag |
| irq | output | 1 | Change interrupt |
| ci0_tx | output | 4 | Transmitted channel 0 code |
| ci1_tx | output | 6 | Transmitted channel 1 field |

## Verification
A host read and a frame tick that latches a fresh code can land in the same cycle. This is the one cycle in which the flag's clear and set compete, and it decides whether a pending code is lost. The bench makes a changed code persist for its second frame exactly in the cycle the read strobe is raised. It checks that the old code is visible during that cycle, and that after the edge the new code is stored with the flag still high. A second contention is between a host write and the minimum hold window. The bench writes at once after an adoption and checks that the output keeps the old code on each of the following ticks and changes exactly on the fourth.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int unsigned CI_MAXW = 8;
  typedef logic [CI_MAXW-1:0] ci_word_t;

  // Two codes agree on every bit selected by the mask.
  function automatic logic masked_same(ci_word_t a, ci_word_t b, ci_word_t m);
    return ((a ^ b) & m) == '0;
  endfunction

  // Saturating frame counter step.
  function automatic int unsigned sat_step(int unsigned cnt, int unsigned lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction
endpackage

// File: rtl/ci_rx_filter.sv
module ci_rx_filter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] rx_i,
  input  logic         rd_i,
  output logic [W-1:0] code_o,
  output logic         chg_o,
  output logic         latch_o
);
  import ci_pkg::*;

  logic [W-1:0] prev_q, code_q;
  logic         seen_q, chg_q;
  ci_word_t     rx_x, prev_x, code_x, mask_x;
  logic         stable, fresh, room;

  assign rx_x   = ci_word_t'(rx_i);
  assign prev_x = ci_word_t'(prev_q);
  assign code_x = ci_word_t'(code_q);
  assign mask_x = ci_word_t'(mask_i);

  assign stable  = seen_q && masked_same(rx_x, prev_x, mask_x);
  assign fresh   = !masked_same(rx_x, code_x, mask_x);
  assign room    = !chg_q || rd_i;
  assign latch_o = tick_i && en_i && stable && fresh && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      seen_q <= 1'b0;
      code_q <= '1;
      chg_q  <= 1'b0;
    end else begin
      if (tick_i) begin
        prev_q <= rx_i;
        seen_q <= 1'b1;
      end
      if (latch_o) begin
        code_q <= rx_i;
        chg_q  <= 1'b1;
      end else if (rd_i) begin
        chg_q  <= 1'b0;
      end
    end
  end

  assign code_o = code_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/ci_tx_slot.sv
module ci_tx_slot #(
  parameter int unsigned W        = 4,
  parameter int unsigned MIN_HOLD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         gate_i,
  output logic [W-1:0] act_o,
  output logic         adopt_o,
  output logic [W-1:0] tx_o
);
  import ci_pkg::*;
  localparam int unsigned CW = $clog2(MIN_HOLD + 1);

  logic [W-1:0]  act_q, pend_q;
  logic          pend_v;
  logic [CW-1:0] cnt_q;
  logic          hold_met;

  assign hold_met = int'(cnt_q) >= int'(MIN_HOLD);
  assign adopt_o  = tick_i && pend_v && hold_met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '1;
      pend_q <= '1;
      pend_v <= 1'b0;
      cnt_q  <= CW'(MIN_HOLD);
    end else begin
      if (tick_i)
        cnt_q <= adopt_o ? CW'(1) : CW'(sat_step(int'(cnt_q), MIN_HOLD));
      if (adopt_o)
        act_q <= pend_q;
      if (wr_i) begin
        pend_q <= wdata_i;
        pend_v <= 1'b1;
      end else if (adopt_o) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign act_o = act_q;
  assign tx_o  = gate_i ? act_q : '1;
endmodule

// File: rtl/ci_link_top.sv
module ci_link_top #(
  parameter int unsigned C0_W     = 4,
  parameter int unsigned C1_W     = 6,
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned MIN_HOLD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic [C0_W-1:0] ci0_rx,
  input  logic [C1_W-1:0] ci1_rx,
  input  logic            bus_held,
  input  logic            ch1_en,
  input  logic            ch1_narrow,
  input  logic            wr0,
  input  logic            wr1,
  input  logic [C1_W-1:0] wdata,
  input  logic            rd0,
  input  logic            rd1,
  output logic [C0_W-1:0] ci0_code,
  output logic [C1_W-1:0] ci1_code,
  output logic            ci0_chg,
  output logic            ci1_chg,
  output logic            irq,
  output logic [C0_W-1:0] ci0_tx,
  output logic [C1_W-1:0] ci1_tx
);
  localparam logic [C0_W-1:0] MASK0 = '1;

  logic [C1_W-1:0] mask1;
  logic            latch0, latch1;
  logic            adopt0, adopt1;
  logic [C0_W-1:0] act0;
  logic [C1_W-1:0] act1;

  generate
    if (C1_W > NARROW_W) begin : g_narrow
      localparam logic [C1_W-1:0] NMASK = {{(C1_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      assign mask1 = ch1_narrow ? NMASK : '1;
    end else begin : g_full
      assign mask1 = '1;
    end
  endgenerate

  ci_rx_filter #(.W(C0_W)) rx0_i (
    .clk(clk), .rst_n(rst_n), .tick_i(frame_tick), .en_i(1'b1),
    .mask_i(MASK0), .rx_i(ci0_rx), .rd_i(rd0),
    .code_o(ci0_code), .chg_o(ci0_chg), .latch_o(latch0)
  );

  ci_rx_filter #(.W(C1_W)) rx1_i (
    .clk(clk), .rst_n(rst_n), .tick_i(frame_tick), .en_i(ch1_en),
    .mask_i(mask1), .rx_i(ci1_rx), .rd_i(rd1),
    .code_o(ci1_code), .chg_o(ci1_chg), .latch_o(latch1)
  );

  ci_tx_slot #(.W(C0_W), .MIN_HOLD(MIN_HOLD)) tx0_i (
    .clk(clk), .rst_n(rst_n), .tick_i(frame_tick), .wr_i(wr0),
    .wdata_i(wdata[C0_W-1:0]), .gate_i(bus_held),
    .act_o(act0), .adopt_o(adopt0), .tx_o(ci0_tx)
  );

  ci_tx_slot #(.W(C1_W), .MIN_HOLD(MIN_HOLD)) tx1_i (
    .clk(clk), .rst_n(rst_n), .tick_i(frame_tick), .wr_i(wr1),
    .wdata_i(wdata), .gate_i(ch1_en),
    .act_o(act1), .adopt_o(adopt1), .tx_o(ci1_tx)
  );

  assign irq = ci0_chg | ci1_chg;
endmodule

// File: rtl/ci_link_chk.sv
module ci_link_chk #(
  parameter int unsigned C0_W     = 4,
  parameter int unsigned C1_W     = 6,
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned MIN_HOLD = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_tick,
  input logic [C0_W-1:0] ci0_rx,
  input logic [C1_W-1:0] ci1_rx,
  input logic            bus_held,
  input logic            ch1_narrow,
  input logic            rd0,
  input logic [C0_W-1:0] ci0_code,
  input logic [C1_W-1:0] ci1_code,
  input logic            ci0_chg,
  input logic [C0_W-1:0] ci0_tx,
  input logic            latch0,
  input logic            latch1,
  input logic [C0_W-1:0] act0
);
  localparam int unsigned CW = $clog2(MIN_HOLD + 1);

  logic [C0_W-1:0] prev0_c, act0_q;
  logic            seen0_c;
  logic [CW-1:0]   since_c;
  logic            act_ev;

  assign act_ev = act0 != act0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev0_c <= '1;
      seen0_c <= 1'b0;
      act0_q  <= '1;
      since_c <= CW'(MIN_HOLD);
    end else begin
      act0_q <= act0;
      if (frame_tick) begin
        prev0_c <= ci0_rx;
        seen0_c <= 1'b1;
      end
      if (act_ev)
        since_c <= frame_tick ? CW'(1) : CW'(0);
      else if (frame_tick && int'(since_c) < int'(MIN_HOLD))
        since_c <= since_c + CW'(1);
    end
  end

  // R1: latch needs the same value two frames running
  p_two_frames_r1: assert property (@(posedge clk) disable iff (!rst_n)
    latch0 |-> (frame_tick && seen0_c && ci0_rx == prev0_c));

  // R2: latch only when the previous code was read
  p_read_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch0 |-> (!ci0_chg || rd0));

  // R3: latch raises the flag and stores the received code
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch0 |=> (ci0_chg && ci0_code == $past(ci0_rx)));

  // R3: a lone read clears the flag
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !latch0) |=> !ci0_chg);

  // R4: transmit changes only at a frame tick or a bus ownership change
  p_tx_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ci0_tx != $past(ci0_tx)) |-> ($past(frame_tick) || bus_held != $past(bus_held)));

  // R5: narrow mode never latches a change confined to the upper bits
  p_narrow_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch1 && ch1_narrow) |-> (ci1_rx[NARROW_W-1:0] != ci1_code[NARROW_W-1:0]));

  // R8: adopted code kept for the minimum number of frames
  p_min_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_ev |-> ($past(frame_tick) && int'($past(since_c)) >= int'(MIN_HOLD) - 1));
endmodule

bind ci_link_top ci_link_chk #(
  .C0_W(C0_W), .C1_W(C1_W), .NARROW_W(NARROW_W), .MIN_HOLD(MIN_HOLD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .ci0_rx(ci0_rx), .ci1_rx(ci1_rx), .bus_held(bus_held),
  .ch1_narrow(ch1_narrow), .rd0(rd0), .ci0_code(ci0_code),
  .ci1_code(ci1_code), .ci0_chg(ci0_chg), .ci0_tx(ci0_tx),
  .latch0(latch0), .latch1(latch1), .act0(act0)
);

// File: tb/ci_link_top_tb_top.sv
`timescale 1ns/1ps
module ci_link_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [3:0] ci0_rx = 4'hF;
  logic [5:0] ci1_rx = 6'h3F;
  logic       bus_held = 1'b0, ch1_en = 1'b0, ch1_narrow = 1'b0;
  logic       wr0 = 1'b0, wr1 = 1'b0, rd0 = 1'b0, rd1 = 1'b0;
  logic [5:0] wdata = '0;
  logic [3:0] ci0_code, ci0_tx;
  logic [5:0] ci1_code, ci1_tx;
  logic       ci0_chg, ci1_chg, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ci_link_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .ci0_rx(ci0_rx), .ci1_rx(ci1_rx), .bus_held(bus_held),
    .ch1_en(ch1_en), .ch1_narrow(ch1_narrow), .wr0(wr0), .wr1(wr1),
    .wdata(wdata), .rd0(rd0), .rd1(rd1), .ci0_code(ci0_code),
    .ci1_code(ci1_code), .ci0_chg(ci0_chg), .ci1_chg(ci1_chg),
    .irq(irq), .ci0_tx(ci0_tx), .ci1_tx(ci1_tx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One frame: inputs set at a falling edge, results read at the next one.
  task automatic frame(input logic [3:0] r0, input logic [5:0] r1,
                       input logic k0, input logic k1);
    @(negedge clk);
    ci0_rx = r0; ci1_rx = r1; rd0 = k0; rd1 = k1; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0; rd0 = 1'b0; rd1 = 1'b0;
  endtask

  task automatic read_pulse(input logic k0, input logic k1);
    @(negedge clk);
    rd0 = k0; rd1 = k1;
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
  endtask

  task automatic write_code(input logic w0, input logic w1, input logic [5:0] d);
    @(negedge clk);
    wr0 = w0; wr1 = w1; wdata = d;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 code0", ci0_code, 4'hF);
    chk("R9 code1", ci1_code, 6'h3F);
    chk("R9 flags", {ci0_chg, ci1_chg, irq}, 0);
    chk("R9 tx0", ci0_tx, 4'hF);
    chk("R9 tx1", ci1_tx, 6'h3F);
  endtask

  task automatic t_persist();
    frame(4'h5, 6'h3F, 0, 0);
    chk("R1 one frame no latch", ci0_code, 4'hF);
    chk("R1 no flag", ci0_chg, 0);
    frame(4'h5, 6'h3F, 0, 0);
    chk("R1 second frame latch", ci0_code, 4'h5);
    chk("R3 flag set", ci0_chg, 1);
    chk("R3 irq", irq, 1);
  endtask

  task automatic t_read_gate();
    frame(4'hA, 6'h3F, 0, 0);
    frame(4'hA, 6'h3F, 0, 0);
    chk("R2 unread blocks latch", ci0_code, 4'h5);
    read_pulse(1, 0);
    chk("R3 read clears flag", ci0_chg, 0);
    chk("R3 irq low", irq, 0);
    chk("R2 code kept", ci0_code, 4'h5);
    frame(4'hA, 6'h3F, 0, 0);
    chk("R2 latch after read", ci0_code, 4'hA);
  endtask

  task automatic t_restart();
    read_pulse(1, 0);
    frame(4'h3, 6'h3F, 0, 0);
    frame(4'h6, 6'h3F, 0, 0);
    frame(4'h3, 6'h3F, 0, 0);
    chk("R10 A B A no latch", ci0_code, 4'hA);
    frame(4'h3, 6'h3F, 0, 0);
    chk("R10 A again latches", ci0_code, 4'h3);
  endtask

  task automatic t_collide();
    frame(4'h9, 6'h3F, 0, 0);
    chk("R7 first frame held", ci0_code, 4'h3);
    @(negedge clk);
    ci0_rx = 4'h9; rd0 = 1'b1; frame_tick = 1'b1;
    #1;
    chk("R7 old code in read cycle", ci0_code, 4'h3);
    @(negedge clk);
    frame_tick = 1'b0; rd0 = 1'b0;
    chk("R7 new code stored", ci0_code, 4'h9);
    chk("R7 flag stays set", ci0_chg, 1);
    read_pulse(1, 0);
  endtask

  task automatic t_narrow();
    ch1_en = 1'b1; ch1_narrow = 1'b1;
    frame(4'h9, 6'h0F, 0, 0);
    frame(4'h9, 6'h0F, 0, 0);
    chk("R5 upper-bit change ignored", ci1_code, 6'h3F);
    chk("R5 no flag", ci1_chg, 0);
    frame(4'h9, 6'h05, 0, 0);
    chk("R1 ch1 one frame", ci1_code, 6'h3F);
    frame(4'h9, 6'h05, 0, 0);
    chk("R5 low bits latch", ci1_code, 6'h05);
    chk("R3 ch1 flag", ci1_chg, 1);
    read_pulse(0, 1);
    frame(4'h9, 6'h35, 0, 0);
    frame(4'h9, 6'h35, 0, 0);
    chk("R5 upper bits ignored", ci1_code, 6'h05);
    chk("R5 flag untouched", ci1_chg, 0);
    ch1_narrow = 1'b0;
    frame(4'h9, 6'h35, 0, 0);
    chk("R5 wide mode sees upper bits", ci1_code, 6'h35);
    read_pulse(0, 1);
  endtask

  task automatic t_disable();
    ch1_en = 1'b0;
    frame(4'h9, 6'h12, 0, 0);
    frame(4'h9, 6'h12, 0, 0);
    chk("R6 disabled no latch", ci1_code, 6'h35);
    chk("R6 disabled no flag", ci1_chg, 0);
    write_code(0, 1, 6'h2A);
    frame(4'h9, 6'h35, 0, 0);
    chk("R6 disabled tx ones", ci1_tx, 6'h3F);
    @(negedge clk); ch1_en = 1'b1; #1;
    chk("R6 enabled tx code", ci1_tx, 6'h2A);
    ch1_narrow = 1'b1;
    write_code(0, 1, 6'h3A);
    for (int i = 0; i < 3; i++) frame(4'h9, 6'h35, 0, 0);
    chk("R8 ch1 held", ci1_tx, 6'h2A);
    frame(4'h9, 6'h35, 0, 0);
    chk("R5 narrow tx keeps upper bits", ci1_tx, 6'h3A);
  endtask

  task automatic t_tx0();
    bus_held = 1'b0;
    write_code(1, 0, 6'h06);
    chk("R4 not held tx ones", ci0_tx, 4'hF);
    @(negedge clk); bus_held = 1'b1; #1;
    chk("R8 write not before tick", ci0_tx, 4'hF);
    frame(4'h9, 6'h35, 0, 0);
    chk("R8 adopted at tick", ci0_tx, 4'h6);
    write_code(1, 0, 6'h07);
    write_code(1, 0, 6'h02);
    for (int i = 1; i <= 3; i++) begin
      frame(4'h9, 6'h35, 0, 0);
      chk($sformatf("R8 held tick %0d", i), ci0_tx, 4'h6);
    end
    frame(4'h9, 6'h35, 0, 0);
    chk("R8 latest write after hold", ci0_tx, 4'h2);
    @(negedge clk); bus_held = 1'b0; #1;
    chk("R4 released tx ones", ci0_tx, 4'hF);
    @(negedge clk); bus_held = 1'b1; #1;
    chk("R4 held again", ci0_tx, 4'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_persist();
    t_read_gate();
    t_restart();
    t_collide();
    t_narrow();
    t_disable();
    t_tx0();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule